// File: doc/BRIEF.md
# Programmable Interval Timer with Compare, Capture and PWM

This block is a 32-bit up-counter driven from the functional clock through an optional power-of-two prescaler. Software programs it through a word-addressed register bus. A reload value can be copied into the counter on every rollover, or on demand by writing a trigger register. A compare register raises a match event. A capture register samples the counter on selected edges of an input pin. A single output pin can toggle or pulse when the counter overflows or matches.

Writes to the control, counter, load, trigger and match registers are posted. They take effect a fixed number of cycles after the bus accepts them, and a write-pending register shows which one is still on its way. Software polls that register until it reads zero before the next posted write. Status, interrupt enable and interface control writes act at once. A soft reset, started through the interface control register, returns every register to its reset value. A status bit reports when that reset has finished. Read data is registered and appears one cycle after the address.

Top module: `gp_timer`

## Requirements
- R1: After reset, control, counter, load, match, capture, interrupt status and interrupt enable read 0. System status (0x14) reads 1, write-pending (0x34) reads 0, and `irq` and `pwm_out` are 0.
- R2: While control bit 0 (run) is 1, the counter (0x28) gains 1 per tick. With control bit 5 clear a tick is every clock. With bit 5 set a tick is every 2^(p+1) clocks, where p is control bits 4:2. While run is 0 the counter holds.
- R3: A tick at counter value 0xFFFFFFFF sets interrupt status bit 1. With control bit 1 set, the counter takes the load value (0x2C). With bit 1 clear, the counter becomes 0 and only control bit 0 is cleared; every other control bit keeps its value.
- R4: Any posted write to the trigger register (0x30), whatever the data, copies the load value into the counter.
- R5: Writes to control (0x24), counter, load, trigger and match (0x38) take effect SYNC_STAGES (default 2) cycles after acceptance. Until then, write-pending reads with bit 0 = control, 1 = counter, 2 = load, 3 = trigger, 4 = match. A posted write accepted while another is pending is discarded.
- R6: With control bit 6 set, a tick that brings the counter to the match value sets interrupt status bit 0. With bit 6 clear, no match status is raised.
- R7: Control bits 9:8 choose the capture edge of `tmr_in` (01 rising, 10 falling, 11 both, 00 none). A chosen edge copies the counter into capture (0x3C) and sets status bit 2. With control bit 13 set, capture is not overwritten while status bit 2 is set.
- R8: Writing 1 to an interrupt status bit (0x18) clears it, and writing 0 leaves it. `irq` is registered: it is the OR over bits 2:0 of status AND enable (0x1C).
- R9: Control bits 11:10 choose the output event (01 overflow, 10 or 11 overflow or match). With control bit 12 set, each event inverts `pwm_out`.
- R10: While run is 0, `pwm_out` equals control bit 7. With control bit 12 clear, each event drives `pwm_out` to the opposite level for one clock.
- R11: Writing interface control (0x40) with bit 1 set (such as 0x06) starts a soft reset of RST_CYCLES clocks. During it, system status bit 0 reads 0 and bus writes are ignored. Afterwards every register is back at its R1 value and bit 0 reads 1.
- R12: `pwm_oe` is 1 when control bit 14 is 0 and 0 when it is 1.
- R13: `bus_rdata` shows the register at `bus_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tmr_in | input | 1 | Capture input pin, asynchronous |
| pwm_out | output | 1 | Toggle/pulse output level |
| pwm_oe | output | 1 | Output-enable for the output pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a rollover: it takes 2^32 ticks from reset. The stimulus reaches it by preloading the counter just below 0xFFFFFFFF through a posted write, then starting the timer. Exact prescaled tick counts depend on the cycle gap between the posted start and the posted stop. The bench sets that gap itself and derives the expected count from it, so random prescale values and gaps can be checked exactly. A discarded posted write is forced by issuing a second write before the first has landed.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int OFF_SYSST = 'h14;
  localparam int OFF_ISTAT = 'h18;
  localparam int OFF_IEN   = 'h1C;
  localparam int OFF_CTRL  = 'h24;
  localparam int OFF_CNT   = 'h28;
  localparam int OFF_LOAD  = 'h2C;
  localparam int OFF_TRIG  = 'h30;
  localparam int OFF_WPEND = 'h34;
  localparam int OFF_MATCH = 'h38;
  localparam int OFF_CAPT  = 'h3C;
  localparam int OFF_IFC   = 'h40;

  // posted-write slot order = write-pending bit order
  localparam int PW_CTRL  = 0;
  localparam int PW_CNT   = 1;
  localparam int PW_LOAD  = 2;
  localparam int PW_TRIG  = 3;
  localparam int PW_MATCH = 4;
  localparam int PW_N     = 5;

  // control field positions
  localparam int C_RUN  = 0;
  localparam int C_AR   = 1;
  localparam int C_PTV  = 2;
  localparam int C_PRE  = 5;
  localparam int C_CE   = 6;
  localparam int C_DEF  = 7;
  localparam int C_EDGE = 8;
  localparam int C_TSEL = 10;
  localparam int C_TOG  = 12;
  localparam int C_HOLD = 13;
  localparam int C_DIR  = 14;
  localparam int CTRL_BITS = 15;
endpackage

// File: rtl/gpt_post_wr.sv
module gpt_post_wr #(
  parameter int DW     = 32,
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [N-1:0]  req_sel,
  input  logic [DW-1:0] req_data,
  output logic [N-1:0]  apply,
  output logic [DW-1:0] apply_data,
  output logic [N-1:0]  pend
);
  localparam int CNTW = $clog2(STAGES + 1);

  logic [CNTW-1:0] cnt;
  logic [N-1:0]    sel;
  logic [DW-1:0]   data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sel  <= '0;
      data <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - CNTW'(1);
      if (cnt == CNTW'(1)) sel <= '0;
    end else if (req) begin
      cnt  <= CNTW'(STAGES);
      sel  <= req_sel;
      data <= req_data;
    end
  end

  assign apply      = (cnt == CNTW'(1)) ? sel : '0;
  assign apply_data = data;
  assign pend       = sel;
endmodule

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       pre_en,
  input  logic [2:0] ptv,
  output logic       tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;
  logic [3:0]       sh;

  always_comb begin
    sh   = {1'b0, ptv} + 4'd1;
    mask = ~({PRE_W{1'b1}} << sh);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pcnt <= '0;
    else             pcnt <= pcnt + PRE_W'(1);
  end

  assign tick = run && (!pre_en || ((pcnt & mask) == mask));
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       evt
);
  logic [SYNC:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], pin};
  end

  logic rise, fall;
  assign rise = sh[SYNC-1] && !sh[SYNC];
  assign fall = !sh[SYNC-1] && sh[SYNC];
  assign evt  = (edge_sel[0] && rise) || (edge_sel[1] && fall);
endmodule

// File: rtl/gpt_pwm_out.sv
module gpt_pwm_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       def_lvl,
  input  logic       toggle,
  input  logic [1:0] trig_sel,
  input  logic       ovf_evt,
  input  logic       match_evt,
  output logic       lvl
);
  logic evt;
  assign evt = ((trig_sel == 2'b01) && ovf_evt) ||
               (trig_sel[1] && (ovf_evt || match_evt));

  always_ff @(posedge clk) begin
    if (rst)         lvl <= 1'b0;
    else if (!run)   lvl <= def_lvl;
    else if (toggle) lvl <= evt ? !lvl : lvl;
    else             lvl <= evt ? !def_lvl : def_lvl;
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer import gpt_pkg::*; #(
  parameter int CW          = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 8,
  parameter int PRE_W       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          tmr_in,
  output logic          pwm_out,
  output logic          pwm_oe,
  output logic          irq
);
  localparam int SRW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CTRL_MASK = CW'((1 << CTRL_BITS) - 1);

  // soft reset sequencer
  logic [SRW-1:0] srst_cnt;
  logic           soft_busy, core_rst, acc_we;
  assign soft_busy = (srst_cnt != '0);
  assign core_rst  = rst || soft_busy;
  assign acc_we    = bus_we && !soft_busy;

  always_ff @(posedge clk) begin
    if (rst)                 srst_cnt <= '0;
    else if (soft_busy)      srst_cnt <= srst_cnt - SRW'(1);
    else if (acc_we && bus_addr == AW'(OFF_IFC) && bus_wdata[1])
                             srst_cnt <= SRW'(RST_CYCLES);
  end

  // posted write path
  logic [PW_N-1:0] pw_sel, apply, pend;
  logic [CW-1:0]   apply_data;
  always_comb begin
    pw_sel = '0;
    pw_sel[PW_CTRL]  = (bus_addr == AW'(OFF_CTRL));
    pw_sel[PW_CNT]   = (bus_addr == AW'(OFF_CNT));
    pw_sel[PW_LOAD]  = (bus_addr == AW'(OFF_LOAD));
    pw_sel[PW_TRIG]  = (bus_addr == AW'(OFF_TRIG));
    pw_sel[PW_MATCH] = (bus_addr == AW'(OFF_MATCH));
  end

  gpt_post_wr #(.DW(CW), .N(PW_N), .STAGES(SYNC_STAGES)) u_post (
    .clk(clk), .rst(core_rst), .req(acc_we && (pw_sel != '0)),
    .req_sel(pw_sel), .req_data(bus_wdata),
    .apply(apply), .apply_data(apply_data), .pend(pend)
  );

  // architectural state
  logic [CW-1:0] ctrl, cnt, load, match, capt;
  logic [2:0]    stat, ien;

  logic tick;
  gpt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(core_rst), .run(ctrl[C_RUN]), .pre_en(ctrl[C_PRE]),
    .ptv(ctrl[C_PTV +: 3]), .tick(tick)
  );

  logic cap_evt;
  gpt_capture #(.SYNC(2)) u_cap (
    .clk(clk), .rst(core_rst), .pin(tmr_in),
    .edge_sel(ctrl[C_EDGE +: 2]), .evt(cap_evt)
  );

  logic          wrap, sw_cnt, ovf_evt, match_evt;
  logic [CW-1:0] tick_val;
  assign wrap      = &cnt;
  assign sw_cnt    = apply[PW_CNT] || apply[PW_TRIG];
  assign tick_val  = wrap ? (ctrl[C_AR] ? load : '0) : cnt + CW'(1);
  assign ovf_evt   = tick && wrap && !sw_cnt;
  assign match_evt = tick && ctrl[C_CE] && !sw_cnt && (tick_val == match);

  logic [2:0] st_set, st_clr;
  assign st_set = {cap_evt, ovf_evt, match_evt};
  assign st_clr = (acc_we && bus_addr == AW'(OFF_ISTAT)) ? bus_wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      ctrl  <= '0;
      cnt   <= '0;
      load  <= '0;
      match <= '0;
      capt  <= '0;
      stat  <= '0;
      ien   <= '0;
    end else begin
      if (apply[PW_CNT])       cnt <= apply_data;
      else if (apply[PW_TRIG]) cnt <= load;
      else if (tick)           cnt <= tick_val;

      if (apply[PW_CTRL])                 ctrl <= apply_data & CTRL_MASK;
      else if (ovf_evt && !ctrl[C_AR])    ctrl[C_RUN] <= 1'b0;

      if (apply[PW_LOAD])  load  <= apply_data;
      if (apply[PW_MATCH]) match <= apply_data;

      if (cap_evt && !(ctrl[C_HOLD] && stat[2])) capt <= cnt;

      stat <= (stat & ~st_clr) | st_set;
      if (acc_we && bus_addr == AW'(OFF_IEN)) ien <= bus_wdata[2:0];
    end
  end

  gpt_pwm_out u_pwm (
    .clk(clk), .rst(core_rst), .run(ctrl[C_RUN]), .def_lvl(ctrl[C_DEF]),
    .toggle(ctrl[C_TOG]), .trig_sel(ctrl[C_TSEL +: 2]),
    .ovf_evt(ovf_evt), .match_evt(match_evt), .lvl(pwm_out)
  );

  assign pwm_oe = !ctrl[C_DIR];

  always_ff @(posedge clk) begin
    if (core_rst) irq <= 1'b0;
    else          irq <= |(stat & ien);
  end

  // registered read mux
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (bus_addr)
        AW'(OFF_SYSST): bus_rdata <= CW'(!soft_busy);
        AW'(OFF_ISTAT): bus_rdata <= CW'(stat);
        AW'(OFF_IEN):   bus_rdata <= CW'(ien);
        AW'(OFF_CTRL):  bus_rdata <= ctrl;
        AW'(OFF_CNT):   bus_rdata <= cnt;
        AW'(OFF_LOAD):  bus_rdata <= load;
        AW'(OFF_WPEND): bus_rdata <= CW'(pend);
        AW'(OFF_MATCH): bus_rdata <= match;
        AW'(OFF_CAPT):  bus_rdata <= capt;
        default:        bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int CW = 32,
  parameter int N  = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_busy,
  input logic          tick,
  input logic [N-1:0]  apply,
  input logic [N-1:0]  pend,
  input logic [CW-1:0] ctrl,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] load,
  input logic [2:0]    stat,
  input logic [2:0]    ien,
  input logic          irq,
  input logic          pwm_out
);
  assert_oneshot_stop_R3: assert property (@(posedge clk) disable iff (rst || soft_busy)
    (tick && (&cnt) && !ctrl[1] && apply == '0) |=>
      (!ctrl[0] && cnt == '0 && ctrl[CW-1:1] == $past(ctrl[CW-1:1]) && stat[1]));

  assert_autoreload_R3: assert property (@(posedge clk) disable iff (rst || soft_busy)
    (tick && (&cnt) && ctrl[1] && apply == '0) |=> (cnt == $past(load) && ctrl[0]));

  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst || soft_busy)
    (!ctrl[0] && apply == '0) |=> $stable(cnt));

  assert_single_pending_R5: assert property (@(posedge clk) disable iff (rst || soft_busy)
    $onehot0(pend));

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst || soft_busy)
    (|(stat & ien)) |=> irq);

  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (rst || soft_busy)
    !(|(stat & ien)) |=> !irq);

  assert_idle_level_R10: assert property (@(posedge clk) disable iff (rst || soft_busy)
    !ctrl[0] |=> (pwm_out == $past(ctrl[7])));
endmodule

bind gp_timer gpt_timer_chk #(.CW(CW), .N(gpt_pkg::PW_N)) u_chk (
  .clk(clk), .rst(rst), .soft_busy(soft_busy), .tick(tick), .apply(apply),
  .pend(pend), .ctrl(ctrl), .cnt(cnt), .load(load), .stat(stat), .ien(ien),
  .irq(irq), .pwm_out(pwm_out)
);

// File: tb/sim_gp_timer.sv
`timescale 1ns/1ps
module sim_gp_timer;
  import gpt_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tmr_in = 1'b0;
  logic        pwm_out, pwm_oe, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gp_timer u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_in(tmr_in),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wr_sync(input int a, input logic [31:0] d);
    logic [31:0] v;
    wr(a, d);
    for (int i = 0; i < 20; i++) begin
      rd(OFF_WPEND, v);
      if (v == 0) break;
    end
  endtask

  // ticks between a posted start and a posted stop separated by gap idle negedges
  function automatic int exp_ticks(input int gap, input int m);
    return (gap + 2) / m;
  endfunction

  task automatic run_for(input logic [31:0] cfg, input int gap);
    wr(OFF_CTRL, cfg | 32'h1);
    repeat (gap) @(negedge clk);
    wr_sync(OFF_CTRL, cfg & ~32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int lo;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    check("R1 irq", 32'(irq), 0);
    check("R1 pwm_out", 32'(pwm_out), 0);
    rd(OFF_CTRL, v);  check("R1 ctrl", v, 0);
    rd(OFF_SYSST, v); check("R1 sysstat", v, 1);
    rd(OFF_WPEND, v); check("R1 wpend", v, 0);
    rd(OFF_CNT, v);   check("R1 counter", v, 0);

    // R5 posted write visibility and discard
    wr(OFF_LOAD, 32'd5);
    rd(OFF_WPEND, v); check("R5 load pending bit2", v, 32'h4);
    rd(OFF_WPEND, v); check("R5 pending cleared", v, 0);
    rd(OFF_LOAD, v);  check("R13 load readback", v, 5);
    wr(OFF_CNT, 32'd7);
    wr(OFF_MATCH, 32'd9);
    repeat (4) @(negedge clk);
    rd(OFF_MATCH, v); check("R5 discarded match", v, 0);
    rd(OFF_CNT, v);   check("R5 counter landed", v, 7);

    // R4 trigger reload
    wr_sync(OFF_LOAD, 32'd100);
    wr_sync(OFF_TRIG, 32'hDEAD_BEEF);
    rd(OFF_CNT, v); check("R4 trigger reload", v, 100);

    // R2 directed: no prescale, then prescale p=2
    wr_sync(OFF_CNT, 0);
    run_for(32'h0, 10);
    rd(OFF_CNT, v); check("R2 undivided count", v, 32'(exp_ticks(10, 1)));
    wr_sync(OFF_CNT, 0);
    run_for(32'h28, 40);
    rd(OFF_CNT, v); check("R2 prescale p2", v, 32'(exp_ticks(40, 8)));
    rd(OFF_CTRL, v); check("R2 stop keeps fields", v, 32'h28);

    // R2 random prescale patterns
    for (int k = 0; k < 8; k++) begin
      int p, gap, pe, m;
      p   = int'($urandom % 4);
      pe  = int'($urandom % 2);
      gap = 3 + int'($urandom % 200);
      m   = pe ? (1 << (p + 1)) : 1;
      wr_sync(OFF_CNT, 0);
      run_for(32'((pe << 5) | (p << 2)), gap);
      rd(OFF_CNT, v); check("R2 random count", v, 32'(exp_ticks(gap, m)));
    end

    // R3 one-shot rollover: p=0 prescale, toggle bit kept
    wr(OFF_ISTAT, 7);
    wr_sync(OFF_CNT, 32'hFFFF_FFF0);
    wr_sync(OFF_CTRL, 32'h1021);
    repeat (60) @(negedge clk);
    rd(OFF_CNT, v);   check("R3 oneshot counter", v, 0);
    rd(OFF_CTRL, v);  check("R3 only run cleared", v, 32'h1020);
    rd(OFF_ISTAT, v); check("R3 overflow status", v, 2);

    // R3 auto-reload
    wr(OFF_ISTAT, 7);
    wr_sync(OFF_LOAD, 32'hAA);
    wr_sync(OFF_CNT, 32'hFFFF_FFFE);
    run_for(32'h2, 10);
    rd(OFF_CNT, v);   check("R3 autoreload count", v, 32'hAA + 32'(exp_ticks(10, 1)) - 2);
    rd(OFF_ISTAT, v); check("R3 autoreload status", v, 2);

    // R6 compare
    wr(OFF_ISTAT, 7);
    wr_sync(OFF_CNT, 0);
    wr_sync(OFF_MATCH, 5);
    run_for(32'h40, 20);
    rd(OFF_ISTAT, v); check("R6 match status", v, 1);

    // R8 interrupt and W1C
    wr(OFF_IEN, 1);
    repeat (3) @(negedge clk);
    check("R8 irq asserted", 32'(irq), 1);
    wr(OFF_ISTAT, 0);
    rd(OFF_ISTAT, v); check("R8 write0 keeps", v, 1);
    wr(OFF_ISTAT, 1);
    rd(OFF_ISTAT, v); check("R8 w1c clears", v, 0);
    repeat (2) @(negedge clk);
    check("R8 irq dropped", 32'(irq), 0);
    wr(OFF_IEN, 0);

    // R6 compare disabled
    wr_sync(OFF_CNT, 0);
    run_for(32'h0, 20);
    rd(OFF_ISTAT, v); check("R6 no match when disabled", v, 0);

    // R7 capture
    wr_sync(OFF_CTRL, 32'h100);
    wr_sync(OFF_CNT, 32'h33);
    tmr_in = 1'b1; repeat (6) @(negedge clk);
    rd(OFF_CAPT, v);  check("R7 rising capture", v, 32'h33);
    rd(OFF_ISTAT, v); check("R7 capture status", v, 4);
    wr(OFF_ISTAT, 4);
    wr_sync(OFF_CNT, 32'h44);
    tmr_in = 1'b0; repeat (6) @(negedge clk);
    rd(OFF_ISTAT, v); check("R7 falling ignored", v, 0);
    rd(OFF_CAPT, v);  check("R7 capture unchanged", v, 32'h33);
    wr_sync(OFF_CTRL, 32'h2300);
    tmr_in = 1'b1; repeat (6) @(negedge clk);
    rd(OFF_CAPT, v);  check("R7 both-edge capture", v, 32'h44);
    wr_sync(OFF_CNT, 32'h55);
    tmr_in = 1'b0; repeat (6) @(negedge clk);
    rd(OFF_CAPT, v);  check("R7 hold while flagged", v, 32'h44);
    wr(OFF_ISTAT, 7);

    // R9 toggle on overflow
    wr_sync(OFF_LOAD, 32'h10);
    wr_sync(OFF_CNT, 32'hFFFF_FFFE);
    wr_sync(OFF_CTRL, 32'h1403);
    repeat (4) @(negedge clk);
    check("R9 toggled high", 32'(pwm_out), 1);
    repeat (10) @(negedge clk);
    check("R9 level kept", 32'(pwm_out), 1);
    wr_sync(OFF_CTRL, 32'h1402);
    check("R10 stopped default low", 32'(pwm_out), 0);

    // R10 pulse on match with default high
    wr_sync(OFF_CTRL, 32'h0880);
    check("R10 stopped default high", 32'(pwm_out), 1);
    check("R12 pin driven", 32'(pwm_oe), 1);
    wr_sync(OFF_CNT, 0);
    wr_sync(OFF_MATCH, 3);
    wr(OFF_CTRL, 32'h08C1);
    lo = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_out == 1'b0) lo++;
    end
    check("R10 one-clock pulse", 32'(lo), 1);
    wr_sync(OFF_CTRL, 32'h4000);
    check("R12 pin released", 32'(pwm_oe), 0);

    // R11 soft reset
    wr_sync(OFF_LOAD, 32'h1234);
    wr(OFF_IFC, 32'h6);
    rd(OFF_SYSST, v); check("R11 reset in progress", v, 0);
    repeat (12) @(negedge clk);
    rd(OFF_SYSST, v); check("R11 reset done", v, 1);
    rd(OFF_CTRL, v);  check("R11 ctrl cleared", v, 0);
    rd(OFF_LOAD, v);  check("R11 load cleared", v, 0);
    check("R11 pwm_oe back", 32'(pwm_oe), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule